// File: doc/BRIEF.md
# Video Memory Arbiter

This block sits in front of two single-port synchronous memories of a display subsystem and decides, every clock, which requester drives each memory. The video memory is shared by three requesters: the processor's software port, a drawing engine and a display-scan reader. The palette (lookup) memory is shared by two: the software port and the palette side of the scan reader. Each requester presents an address, write data, an active-low write strobe and an active-low chip enable. The arbiter forwards the winner's signals to the memory in the same cycle.

The software port always wins. On the video memory, the drawing engine and the scan reader split the cycles software leaves free, taking turns when both ask. On the palette memory the scan reader only gets cycles that software does not use. The scan reader never writes: its write strobe is held inactive and its write data is zero inside the block.

The handshake works like a stream ready. A requester that is not granted keeps its chip enable low and its address stable. It gets no acknowledge that cycle, so a lost cycle is back-pressure and nothing is dropped. A non-software requester sees its `*_rdy_nxt` flag high in the cycle it is granted. That is one clock before the memory's read data, which is fanned out to every requester's data output, is valid for it. Software has no flag because it is never refused.

Top module: `vma_top`

## Requirements
- R1: While `cpu_vid_ce_n` is 0 (0 = request on every chip enable and write strobe), the video memory port carries the software address, write data and write strobe in that same cycle with `vid_mem_ce_n` = 0. `drw_rdy_nxt` and `scn_vid_rdy_nxt` are both 0.
- R2: When software is idle and both `drw_ce_n` and `scn_vid_ce_n` are 0, the contested cycles alternate between the drawing engine and the scan reader. The first contested cycle after reset goes to the drawing engine. The turn passes only when a contested cycle is granted.
- R3: When software is idle and only one of the drawing engine or the scan reader requests, that requester is granted in the same cycle and the turn is left unchanged.
- R4: On the palette memory, a software request (`cpu_pal_ce_n` = 0) is always served in its cycle. The scan reader (`scn_pal_ce_n` = 0) is served, with `scn_pal_rdy_nxt` = 1, only in cycles without a software request.
- R5: `drw_rdy_nxt`, `scn_vid_rdy_nxt` and `scn_pal_rdy_nxt` are 1 exactly in the cycle their requester is granted. At most one video flag is 1 per cycle. The memory's read data, valid the following cycle, appears unchanged on every requester's read-data output.
- R6: Whenever the scan reader is granted on either memory, the memory write strobe is 1 and the memory write data is all zeros.
- R7: In a cycle with no request on a memory, its chip enable and write strobe are 1. Its address and write data keep the values of the last granted access.
- R8: After reset, with no requests, both memory chip enables are 1, both memory addresses and write data are zero, and all ready-next flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_vid_addr | input | VAW | Software video address |
| cpu_vid_wdata | input | DW | Software video write data |
| cpu_vid_we_n | input | 1 | Software video write strobe, active low |
| cpu_vid_ce_n | input | 1 | Software video chip enable, active low |
| cpu_vid_rdata | output | DW | Video read data to software |
| drw_addr | input | VAW | Drawing engine address |
| drw_wdata | input | DW | Drawing engine write data |
| drw_we_n | input | 1 | Drawing engine write strobe, active low |
| drw_ce_n | input | 1 | Drawing engine chip enable, active low |
| drw_rdata | output | DW | Video read data to drawing engine |
| drw_rdy_nxt | output | 1 | Drawing engine granted; data valid next cycle |
| scn_vid_addr | input | VAW | Scan reader video address |
| scn_vid_ce_n | input | 1 | Scan reader video chip enable, active low |
| scn_vid_rdata | output | DW | Video read data to scan reader |
| scn_vid_rdy_nxt | output | 1 | Scan reader video granted; data valid next cycle |
| vid_mem_addr | output | VAW | Video memory address |
| vid_mem_wdata | output | DW | Video memory write data |
| vid_mem_we_n | output | 1 | Video memory write strobe, active low |
| vid_mem_ce_n | output | 1 | Video memory chip enable, active low |
| vid_mem_rdata | input | DW | Video memory read data |
| cpu_pal_addr | input | PAW | Software palette address |
| cpu_pal_wdata | input | DW | Software palette write data |
| cpu_pal_we_n | input | 1 | Software palette write strobe, active low |
| cpu_pal_ce_n | input | 1 | Software palette chip enable, active low |
| cpu_pal_rdata | output | DW | Palette read data to software |
| scn_pal_addr | input | PAW | Scan reader palette address |
| scn_pal_ce_n | input | 1 | Scan reader palette chip enable, active low |
| scn_pal_rdata | output | DW | Palette read data to scan reader |
| scn_pal_rdy_nxt | output | 1 | Scan reader palette granted; data valid next cycle |
| pal_mem_addr | output | PAW | Palette memory address |
| pal_mem_wdata | output | DW | Palette memory write data |
| pal_mem_we_n | output | 1 | Palette memory write strobe, active low |
| pal_mem_ce_n | output | 1 | Palette memory chip enable, active low |
| pal_mem_rdata | input | DW | Palette memory read data |

## Verification
Memory-side signals and ready-next flags are combinational on the requests, so they are due in the same cycle as the stimulus. Read data is due one cycle after the ready flag, once the memory has registered the address. The turn pointer and the held address and data change at the clock edge and show only in the next cycle. The bench therefore drives inputs on the falling edge, compares grants and memory signals one nanosecond later in the same cycle, and checks read data a cycle later against addresses it recorded itself.

// File: rtl/vma_pkg.sv
package vma_pkg;
  // requester slot positions inside a request/grant vector
  localparam int SLOT_CPU   = 0;
  localparam int SLOT_FIRST = 1;
  localparam int SLOT_SECND = 2;

  function automatic logic [31:0] lowest_set(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction
endpackage

// File: rtl/vma_grant.sv
module vma_grant #(
  parameter int NREQ        = 3,
  parameter bit ROUND_ROBIN = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] gnt
);
  import vma_pkg::*;

  generate
    if (ROUND_ROBIN && NREQ == 3) begin : g_rr
      logic turn_second;
      logic contested;

      assign contested = req[SLOT_FIRST] & req[SLOT_SECND] & ~req[SLOT_CPU];

      always_comb begin
        gnt = '0;
        if (req[SLOT_CPU])          gnt[SLOT_CPU]   = 1'b1;
        else if (contested)         gnt[turn_second ? SLOT_SECND : SLOT_FIRST] = 1'b1;
        else if (req[SLOT_FIRST])   gnt[SLOT_FIRST] = 1'b1;
        else if (req[SLOT_SECND])   gnt[SLOT_SECND] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          turn_second <= 1'b0;
        else if (contested)  turn_second <= ~turn_second;
      end

      // R2: two contested cycles in a row go to different requesters
      assert_rr_alt_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(contested && gnt[SLOT_FIRST]) && contested) |-> gnt[SLOT_SECND]);
      assert_rr_alt_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(contested && gnt[SLOT_SECND]) && contested) |-> gnt[SLOT_FIRST]);
      // R3: a lone shared request is served at once
      assert_lone_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req[SLOT_FIRST] && !req[SLOT_SECND] && !req[SLOT_CPU]) |-> gnt[SLOT_FIRST]);
      assert_lone_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req[SLOT_SECND] && !req[SLOT_FIRST] && !req[SLOT_CPU]) |-> gnt[SLOT_SECND]);
    end else begin : g_fixed
      always_comb begin
        logic [31:0] wide;
        wide = lowest_set(32'(req));
        gnt  = wide[NREQ-1:0];
      end
    end
  endgenerate

  // R5: one winner at most per memory
  assert_one_winner_R5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
endmodule

// File: rtl/vma_port_mux.sv
module vma_port_mux #(
  parameter int N  = 3,
  parameter int AW = 15,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         gnt,
  input  logic [N-1:0][AW-1:0] req_addr,
  input  logic [N-1:0][DW-1:0] req_wdata,
  input  logic [N-1:0]         req_we_n,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  output logic                 mem_we_n,
  output logic                 mem_ce_n
);
  logic [N-1:0][AW-1:0] a_term;
  logic [N-1:0][DW-1:0] d_term;
  logic [AW-1:0]        sel_addr, hold_addr;
  logic [DW-1:0]        sel_wdata, hold_wdata;
  logic                 active;

  generate
    for (genvar i = 0; i < N; i++) begin : g_term
      assign a_term[i] = gnt[i] ? req_addr[i]  : '0;
      assign d_term[i] = gnt[i] ? req_wdata[i] : '0;
    end
  endgenerate

  always_comb begin
    sel_addr  = '0;
    sel_wdata = '0;
    for (int i = 0; i < N; i++) begin
      sel_addr  = sel_addr  | a_term[i];
      sel_wdata = sel_wdata | d_term[i];
    end
  end

  assign active    = |gnt;
  assign mem_ce_n  = ~active;
  assign mem_we_n  = ~(|(gnt & ~req_we_n));
  assign mem_addr  = active ? sel_addr  : hold_addr;
  assign mem_wdata = active ? sel_wdata : hold_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_addr  <= '0;
      hold_wdata <= '0;
    end else if (active) begin
      hold_addr  <= sel_addr;
      hold_wdata <= sel_wdata;
    end
  end

  // R7: idle memory never sees a write and keeps its address/data
  assert_idle_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> mem_we_n);
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mem_ce_n) |-> ($stable(mem_addr) && $stable(mem_wdata)));
endmodule

// File: rtl/vma_top.sv
module vma_top #(
  parameter int VAW = 15,
  parameter int PAW = 9,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [VAW-1:0] cpu_vid_addr,
  input  logic [DW-1:0]  cpu_vid_wdata,
  input  logic           cpu_vid_we_n,
  input  logic           cpu_vid_ce_n,
  output logic [DW-1:0]  cpu_vid_rdata,
  input  logic [VAW-1:0] drw_addr,
  input  logic [DW-1:0]  drw_wdata,
  input  logic           drw_we_n,
  input  logic           drw_ce_n,
  output logic [DW-1:0]  drw_rdata,
  output logic           drw_rdy_nxt,
  input  logic [VAW-1:0] scn_vid_addr,
  input  logic           scn_vid_ce_n,
  output logic [DW-1:0]  scn_vid_rdata,
  output logic           scn_vid_rdy_nxt,
  output logic [VAW-1:0] vid_mem_addr,
  output logic [DW-1:0]  vid_mem_wdata,
  output logic           vid_mem_we_n,
  output logic           vid_mem_ce_n,
  input  logic [DW-1:0]  vid_mem_rdata,
  input  logic [PAW-1:0] cpu_pal_addr,
  input  logic [DW-1:0]  cpu_pal_wdata,
  input  logic           cpu_pal_we_n,
  input  logic           cpu_pal_ce_n,
  output logic [DW-1:0]  cpu_pal_rdata,
  input  logic [PAW-1:0] scn_pal_addr,
  input  logic           scn_pal_ce_n,
  output logic [DW-1:0]  scn_pal_rdata,
  output logic           scn_pal_rdy_nxt,
  output logic [PAW-1:0] pal_mem_addr,
  output logic [DW-1:0]  pal_mem_wdata,
  output logic           pal_mem_we_n,
  output logic           pal_mem_ce_n,
  input  logic [DW-1:0]  pal_mem_rdata
);
  import vma_pkg::*;

  localparam int NVID = 3;
  localparam int NPAL = 2;

  // ---------------- video memory ----------------
  logic [NVID-1:0]          vid_req, vid_gnt;
  logic [NVID-1:0][VAW-1:0] vid_addr_v;
  logic [NVID-1:0][DW-1:0]  vid_wdata_v;
  logic [NVID-1:0]          vid_we_v;

  assign vid_req[SLOT_CPU]       = ~cpu_vid_ce_n;
  assign vid_req[SLOT_FIRST]     = ~drw_ce_n;
  assign vid_req[SLOT_SECND]     = ~scn_vid_ce_n;
  assign vid_addr_v[SLOT_CPU]    = cpu_vid_addr;
  assign vid_addr_v[SLOT_FIRST]  = drw_addr;
  assign vid_addr_v[SLOT_SECND]  = scn_vid_addr;
  assign vid_wdata_v[SLOT_CPU]   = cpu_vid_wdata;
  assign vid_wdata_v[SLOT_FIRST] = drw_wdata;
  assign vid_wdata_v[SLOT_SECND] = '0;     // scan reader is read-only
  assign vid_we_v[SLOT_CPU]      = cpu_vid_we_n;
  assign vid_we_v[SLOT_FIRST]    = drw_we_n;
  assign vid_we_v[SLOT_SECND]    = 1'b1;

  vma_grant #(.NREQ(NVID), .ROUND_ROBIN(1'b1)) u_vid_grant (
    .clk(clk), .rst_n(rst_n), .req(vid_req), .gnt(vid_gnt)
  );

  vma_port_mux #(.N(NVID), .AW(VAW), .DW(DW)) u_vid_mux (
    .clk(clk), .rst_n(rst_n), .gnt(vid_gnt),
    .req_addr(vid_addr_v), .req_wdata(vid_wdata_v), .req_we_n(vid_we_v),
    .mem_addr(vid_mem_addr), .mem_wdata(vid_mem_wdata),
    .mem_we_n(vid_mem_we_n), .mem_ce_n(vid_mem_ce_n)
  );

  assign drw_rdy_nxt     = vid_gnt[SLOT_FIRST];
  assign scn_vid_rdy_nxt = vid_gnt[SLOT_SECND];
  assign cpu_vid_rdata   = vid_mem_rdata;
  assign drw_rdata       = vid_mem_rdata;
  assign scn_vid_rdata   = vid_mem_rdata;

  // ---------------- palette memory ----------------
  logic [NPAL-1:0]          pal_req, pal_gnt;
  logic [NPAL-1:0][PAW-1:0] pal_addr_v;
  logic [NPAL-1:0][DW-1:0]  pal_wdata_v;
  logic [NPAL-1:0]          pal_we_v;

  assign pal_req[SLOT_CPU]       = ~cpu_pal_ce_n;
  assign pal_req[SLOT_FIRST]     = ~scn_pal_ce_n;
  assign pal_addr_v[SLOT_CPU]    = cpu_pal_addr;
  assign pal_addr_v[SLOT_FIRST]  = scn_pal_addr;
  assign pal_wdata_v[SLOT_CPU]   = cpu_pal_wdata;
  assign pal_wdata_v[SLOT_FIRST] = '0;
  assign pal_we_v[SLOT_CPU]      = cpu_pal_we_n;
  assign pal_we_v[SLOT_FIRST]    = 1'b1;

  vma_grant #(.NREQ(NPAL), .ROUND_ROBIN(1'b0)) u_pal_grant (
    .clk(clk), .rst_n(rst_n), .req(pal_req), .gnt(pal_gnt)
  );

  vma_port_mux #(.N(NPAL), .AW(PAW), .DW(DW)) u_pal_mux (
    .clk(clk), .rst_n(rst_n), .gnt(pal_gnt),
    .req_addr(pal_addr_v), .req_wdata(pal_wdata_v), .req_we_n(pal_we_v),
    .mem_addr(pal_mem_addr), .mem_wdata(pal_mem_wdata),
    .mem_we_n(pal_mem_we_n), .mem_ce_n(pal_mem_ce_n)
  );

  assign scn_pal_rdy_nxt = pal_gnt[SLOT_FIRST];
  assign cpu_pal_rdata   = pal_mem_rdata;
  assign scn_pal_rdata   = pal_mem_rdata;

  // ---------------- port-level checks ----------------
  assert_cpu_vid_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_vid_ce_n |-> (!vid_mem_ce_n && vid_mem_addr == cpu_vid_addr &&
                       vid_mem_we_n == cpu_vid_we_n && !drw_rdy_nxt && !scn_vid_rdy_nxt));
  assert_cpu_pal_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_pal_ce_n |-> (!pal_mem_ce_n && pal_mem_addr == cpu_pal_addr && !scn_pal_rdy_nxt));
  assert_pal_scan_served_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_pal_ce_n && !scn_pal_ce_n) |-> (scn_pal_rdy_nxt && pal_mem_addr == scn_pal_addr));
  assert_drw_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drw_rdy_nxt |-> (!vid_mem_ce_n && vid_mem_addr == drw_addr));
  assert_scan_read_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scn_vid_rdy_nxt |-> (vid_mem_we_n && vid_mem_wdata == '0)) and
    (scn_pal_rdy_nxt |-> (pal_mem_we_n && pal_mem_wdata == '0)));
endmodule

// File: tb/vma_top_tb.sv
module vma_top_tb;
  localparam int VAW = 15;
  localparam int PAW = 9;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [VAW-1:0] cpu_vid_addr = '0, drw_addr = '0, scn_vid_addr = '0;
  logic [DW-1:0]  cpu_vid_wdata = '0, drw_wdata = '0;
  logic           cpu_vid_we_n = 1'b1, cpu_vid_ce_n = 1'b1;
  logic           drw_we_n = 1'b1, drw_ce_n = 1'b1, scn_vid_ce_n = 1'b1;
  logic [DW-1:0]  cpu_vid_rdata, drw_rdata, scn_vid_rdata;
  logic           drw_rdy_nxt, scn_vid_rdy_nxt;
  logic [VAW-1:0] vid_mem_addr;
  logic [DW-1:0]  vid_mem_wdata;
  logic           vid_mem_we_n, vid_mem_ce_n;
  logic [DW-1:0]  vid_mem_rdata = '0;
  logic [PAW-1:0] cpu_pal_addr = '0, scn_pal_addr = '0;
  logic [DW-1:0]  cpu_pal_wdata = '0;
  logic           cpu_pal_we_n = 1'b1, cpu_pal_ce_n = 1'b1, scn_pal_ce_n = 1'b1;
  logic [DW-1:0]  cpu_pal_rdata, scn_pal_rdata;
  logic           scn_pal_rdy_nxt;
  logic [PAW-1:0] pal_mem_addr;
  logic [DW-1:0]  pal_mem_wdata;
  logic           pal_mem_we_n, pal_mem_ce_n;
  logic [DW-1:0]  pal_mem_rdata = '0;

  vma_top #(.VAW(VAW), .PAW(PAW), .DW(DW)) u_dut (.*);

  // memory stand-ins: one-cycle read latency, contents derived from address
  function automatic logic [DW-1:0] vcont(input logic [31:0] a);
    return DW'(a * 37 + 5);
  endfunction
  function automatic logic [DW-1:0] pcont(input logic [31:0] a);
    return DW'(a * 91 + 17) ^ 16'h5a00;
  endfunction
  always @(posedge clk) begin
    if (!vid_mem_ce_n) vid_mem_rdata <= vcont(32'(vid_mem_addr));
    if (!pal_mem_ce_n) pal_mem_rdata <= pcont(32'(pal_mem_addr));
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference state
  int turn = 0;                       // 0: drawing engine next on contest
  logic [31:0] v_hold_a = 0, v_hold_d = 0, p_hold_a = 0, p_hold_d = 0;
  int v_pend = -1;                    // requester whose read lands next cycle
  logic [31:0] v_pend_a = 0;
  bit p_pend = 0;
  logic [31:0] p_pend_a = 0;

  // called right after a falling edge once inputs are set
  task automatic cycle();
    int w; bit cont; string vt; logic [31:0] ea, ed; logic ew;
    #1;
    // read data due from last cycle's grant
    if (v_pend == 1) chk("R5 drw_rdata", 32'(drw_rdata), 32'(vcont(v_pend_a)));
    if (v_pend == 2) chk("R5 scn_vid_rdata", 32'(scn_vid_rdata), 32'(vcont(v_pend_a)));
    if (v_pend == 0) chk("R5 cpu_vid_rdata", 32'(cpu_vid_rdata), 32'(vcont(v_pend_a)));
    if (p_pend)      chk("R5 scn_pal_rdata", 32'(scn_pal_rdata), 32'(pcont(p_pend_a)));

    // video memory
    cont = 0;
    if (!cpu_vid_ce_n) begin w = 0; vt = "R1"; end
    else if (!drw_ce_n && !scn_vid_ce_n) begin w = (turn == 0) ? 1 : 2; cont = 1; vt = "R2"; end
    else if (!drw_ce_n)     begin w = 1; vt = "R3"; end
    else if (!scn_vid_ce_n) begin w = 2; vt = "R3"; end
    else begin w = -1; vt = "R7"; end
    case (w)
      0: begin ea = 32'(cpu_vid_addr); ed = 32'(cpu_vid_wdata); ew = cpu_vid_we_n; end
      1: begin ea = 32'(drw_addr); ed = 32'(drw_wdata); ew = drw_we_n; end
      2: begin ea = 32'(scn_vid_addr); ed = 0; ew = 1'b1; end
      default: begin ea = v_hold_a; ed = v_hold_d; ew = 1'b1; end
    endcase
    chk({vt, " vid_mem_ce_n"}, 32'(vid_mem_ce_n), (w < 0) ? 1 : 0);
    chk({vt, " vid_mem_addr"}, 32'(vid_mem_addr), ea);
    chk({vt, " vid_mem_wdata"}, 32'(vid_mem_wdata), ed);
    chk({vt, " vid_mem_we_n"}, 32'(vid_mem_we_n), 32'(ew));
    if (w == 2) chk("R6 vid scan read-only", {vid_mem_we_n, 15'd0, vid_mem_wdata}, 32'h8000_0000);
    chk("R5 drw_rdy_nxt", 32'(drw_rdy_nxt), (w == 1) ? 1 : 0);
    chk("R5 scn_vid_rdy_nxt", 32'(scn_vid_rdy_nxt), (w == 2) ? 1 : 0);
    if (w >= 0) begin v_hold_a = ea; v_hold_d = ed; end
    if (cont) turn = 1 - turn;
    v_pend = w; v_pend_a = ea;

    // palette memory
    if (!cpu_pal_ce_n) begin
      chk("R4 pal cpu ce", 32'(pal_mem_ce_n), 0);
      chk("R4 pal cpu addr", 32'(pal_mem_addr), 32'(cpu_pal_addr));
      chk("R4 pal cpu wdata", 32'(pal_mem_wdata), 32'(cpu_pal_wdata));
      chk("R4 pal cpu we", 32'(pal_mem_we_n), 32'(cpu_pal_we_n));
      chk("R4 scn_pal_rdy_nxt", 32'(scn_pal_rdy_nxt), 0);
      p_hold_a = 32'(cpu_pal_addr); p_hold_d = 32'(cpu_pal_wdata); p_pend = 0;
    end else if (!scn_pal_ce_n) begin
      chk("R4 pal scan ce", 32'(pal_mem_ce_n), 0);
      chk("R4 pal scan addr", 32'(pal_mem_addr), 32'(scn_pal_addr));
      chk("R6 pal scan read-only", {pal_mem_we_n, 15'd0, pal_mem_wdata}, 32'h8000_0000);
      chk("R4 scn_pal_rdy_nxt", 32'(scn_pal_rdy_nxt), 1);
      p_hold_a = 32'(scn_pal_addr); p_hold_d = 0; p_pend = 1; p_pend_a = p_hold_a;
    end else begin
      chk("R7 pal idle ce", 32'(pal_mem_ce_n), 1);
      chk("R7 pal idle we", 32'(pal_mem_we_n), 1);
      chk("R7 pal idle addr", 32'(pal_mem_addr), p_hold_a);
      chk("R7 pal idle wdata", 32'(pal_mem_wdata), p_hold_d);
      chk("R5 scn_pal_rdy_nxt idle", 32'(scn_pal_rdy_nxt), 0);
      p_pend = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle_all();
    cpu_vid_ce_n = 1; drw_ce_n = 1; scn_vid_ce_n = 1; cpu_pal_ce_n = 1; scn_pal_ce_n = 1;
    cpu_vid_we_n = 1; drw_we_n = 1; cpu_pal_we_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset vid ce", 32'(vid_mem_ce_n), 1);
    chk("R8 reset pal ce", 32'(pal_mem_ce_n), 1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 vid addr", 32'(vid_mem_addr), 0);
    chk("R8 vid wdata", 32'(vid_mem_wdata), 0);
    chk("R8 pal addr", 32'(pal_mem_addr), 0);
    chk("R8 flags", {29'd0, drw_rdy_nxt, scn_vid_rdy_nxt, scn_pal_rdy_nxt}, 0);
    @(negedge clk);

    // R1: software writes and reads while both others wait
    drw_ce_n = 0; scn_vid_ce_n = 0; drw_addr = 15'h0111; scn_vid_addr = 15'h0222;
    for (int i = 0; i < 4; i++) begin
      cpu_vid_ce_n = 0; cpu_vid_we_n = i[0]; cpu_vid_addr = 15'(16 + i); cpu_vid_wdata = 16'(i * 3 + 1);
      cycle();
    end
    // R2: contested alternation, engine first
    cpu_vid_ce_n = 1;
    for (int i = 0; i < 6; i++) begin drw_addr = 15'(100 + i); scn_vid_addr = 15'(200 + i); cycle(); end
    // R3: lone requests leave the turn alone
    scn_vid_ce_n = 1; cycle(); cycle();
    scn_vid_ce_n = 0; drw_ce_n = 1; cycle();
    drw_ce_n = 0; cycle(); cycle();
    // R7: idle holds last values
    idle_all(); cycle(); cycle();
    // R4: palette priority and background reads
    cpu_pal_ce_n = 0; cpu_pal_we_n = 0; cpu_pal_addr = 9'h012; cpu_pal_wdata = 16'hbeef;
    scn_pal_ce_n = 0; scn_pal_addr = 9'h0a5; cycle(); cycle();
    cpu_pal_ce_n = 1; cycle(); cycle();
    idle_all(); cycle();

    for (int n = 0; n < 4000; n++) begin
      cpu_vid_ce_n  = ($urandom_range(0, 3) != 0);
      drw_ce_n      = $urandom_range(0, 1);
      scn_vid_ce_n  = $urandom_range(0, 1);
      cpu_vid_we_n  = $urandom_range(0, 1);
      drw_we_n      = $urandom_range(0, 1);
      cpu_vid_addr  = 15'($urandom); drw_addr = 15'($urandom); scn_vid_addr = 15'($urandom);
      cpu_vid_wdata = 16'($urandom); drw_wdata = 16'($urandom);
      cpu_pal_ce_n  = ($urandom_range(0, 2) != 0);
      scn_pal_ce_n  = $urandom_range(0, 1);
      cpu_pal_we_n  = $urandom_range(0, 1);
      cpu_pal_addr  = 9'($urandom); scn_pal_addr = 9'($urandom); cpu_pal_wdata = 16'($urandom);
      cycle();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired, actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule